// File: doc/BRIEF.md
# Paged Read Address Sequencer

This block produces the byte position for a read stream taken from a page-organised flash array. A command decoder loads it with a start address, a read type and a page-size mode. A consumer then pulses a next-byte request once per byte, and the block steps the position according to the read type that was latched at load time. The position is given as a page index and a byte index within that page.

Two page layouts are supported. The standard layout has 264 bytes per page. Its start address carries an 11-bit page field above a 9-bit byte field. The binary layout has 256 bytes per page. Its start address is a flat 19-bit linear value, so the page is the upper 11 bits and the byte is the lower 8 bits. Three read types are handled:
- A continuous read runs across page boundaries with no pause.
- A single-page read loops inside one page.
- A 128-byte security-register read marks its output invalid once it passes the last byte.

Top module: `paged_rd_seq`

## Requirements
- R1: After reset, page_o is 0, byte_o is 0 and valid_o is 0. While valid_o is 0 and load_i is low, next_i pulses leave all outputs unchanged.
- R2: A load_i pulse updates the outputs on the following cycle and sets valid_o to 1. With bin_mode_i=0, page_o is start_addr_i[19:9] and byte_o is start_addr_i[8:0]. With bin_mode_i=1, page_o is start_addr_i[18:8], byte_o is start_addr_i[7:0], and bit 19 is ignored.
- R3: Continuous read (rd_type_i=2'b00, and also the spare code 2'b11) works as follows. Each accepted next_i adds one to byte_o. At the last byte of the page (263 standard, 255 binary), the next cycle shows byte 0 of page_o+1, with no idle cycle between.
- R4: Single-page read (rd_type_i=2'b01): at the last byte of the page, next_i returns byte_o to 0 and page_o stays the same.
- R5: A continuous read that steps past the last byte of page 2047 continues at page 0, byte 0.
- R6: In standard mode, a loaded byte field of 264 or more is reduced by 264. For example, 300 becomes 36 and 511 becomes 247.
- R7: Security read (rd_type_i=2'b10) starts at page 0, byte 0, whatever the address. It steps through bytes 0 to 127. A next_i at byte 127 clears valid_o, leaves byte_o at 127, and has no further effect afterwards.
- R8: When load_i and next_i are high in the same cycle, the load wins and no step is applied.
- R9: rd_type_i and bin_mode_i are sampled only on load. Changing them between loads does not alter how next_i steps.
- R10: While valid_o is 1, byte_o is always below the size of the active page (264, 256 or 128).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load the start position from start_addr_i |
| start_addr_i | input | 20 | Start address, {page, byte} in standard mode, linear in binary mode |
| rd_type_i | input | 2 | 00 continuous, 01 single page, 10 security register, 11 continuous |
| bin_mode_i | input | 1 | 1 selects the 256-byte binary layout |
| next_i | input | 1 | Advance by one byte |
| page_o | output | 11 | Current page index |
| byte_o | output | 9 | Current byte index within the page |
| valid_o | output | 1 | Position is meaningful |

## Verification
The position state lives in the output registers, so a wrong internal step becomes visible at page_o or byte_o in the cycle after the offending next_i. A broken wrap limit shows up as byte 264 or 256 instead of 0 at the boundary step. A missing clamp shows as a byte above 263 directly after load. The latched read type and mode are observed indirectly: the bench changes the type inputs between loads and checks that the boundary behaviour of the next step still follows the loaded type.

// File: rtl/paged_rd_seq_pkg.sv
package paged_rd_seq_pkg;

   typedef enum logic [1:0] {
      RK_CONT = 2'd0,
      RK_PAGE = 2'd1,
      RK_SECR = 2'd2,
      RK_ALT  = 2'd3
   } rd_kind_e;

endpackage

// File: rtl/prs_start_decode.sv
module prs_start_decode
   import paged_rd_seq_pkg::*;
#(
   parameter int PAGE_W         = 11,
   parameter int BYTE_W         = 9,
   parameter int BIN_BYTE_W     = 8,
   parameter int STD_PAGE_BYTES = 264,
   localparam int ADDR_W        = PAGE_W + BYTE_W
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              bin_i,
   input  rd_kind_e          kind_i,
   output logic [PAGE_W-1:0] page_o,
   output logic [BYTE_W-1:0] byte_o
);

   logic [BYTE_W-1:0] std_raw;
   logic [BYTE_W-1:0] std_fit;

   assign std_raw = addr_i[BYTE_W-1:0];

   generate
      if (STD_PAGE_BYTES == (1 << BYTE_W)) begin : g_pow2
         assign std_fit = std_raw;
      end else begin : g_clamp
         localparam logic [BYTE_W-1:0] SPAN = BYTE_W'(STD_PAGE_BYTES);
         assign std_fit = (std_raw >= SPAN) ? (std_raw - SPAN) : std_raw;
      end
   endgenerate

   always_comb begin
      if (kind_i == RK_SECR) begin
         page_o = '0;
         byte_o = '0;
      end else if (bin_i) begin
         page_o = addr_i[PAGE_W+BIN_BYTE_W-1:BIN_BYTE_W];
         byte_o = BYTE_W'(addr_i[BIN_BYTE_W-1:0]);
      end else begin
         page_o = addr_i[ADDR_W-1:BYTE_W];
         byte_o = std_fit;
      end
   end

endmodule

// File: rtl/prs_page_step.sv
module prs_page_step #(
   parameter int PAGE_W    = 11,
   parameter int NUM_PAGES = 2048
) (
   input  logic [PAGE_W-1:0] cur_i,
   output logic [PAGE_W-1:0] nxt_o
);

   generate
      if (NUM_PAGES == (1 << PAGE_W)) begin : g_natural
         assign nxt_o = cur_i + 1'b1;
      end else begin : g_bounded
         localparam logic [PAGE_W-1:0] TOP = PAGE_W'(NUM_PAGES - 1);
         assign nxt_o = (cur_i == TOP) ? '0 : cur_i + 1'b1;
      end
   endgenerate

endmodule

// File: rtl/prs_byte_step.sv
module prs_byte_step #(
   parameter int BYTE_W = 9
) (
   input  logic [BYTE_W-1:0] cur_i,
   input  logic [BYTE_W-1:0] last_i,
   output logic              at_end_o,
   output logic [BYTE_W-1:0] inc_o
);

   assign at_end_o = (cur_i == last_i);
   assign inc_o    = cur_i + 1'b1;

endmodule

// File: rtl/paged_rd_seq.sv
module paged_rd_seq
   import paged_rd_seq_pkg::*;
#(
   parameter int PAGE_W         = 11,
   parameter int BYTE_W         = 9,
   parameter int BIN_BYTE_W     = 8,
   parameter int STD_PAGE_BYTES = 264,
   parameter int SEC_BYTES      = 128,
   parameter int NUM_PAGES      = 2048,
   localparam int ADDR_W        = PAGE_W + BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [1:0]        rd_type_i,
   input  logic              bin_mode_i,
   input  logic              next_i,
   output logic [PAGE_W-1:0] page_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              valid_o
);

   localparam logic [BYTE_W-1:0] STD_LAST = BYTE_W'(STD_PAGE_BYTES - 1);
   localparam logic [BYTE_W-1:0] BIN_LAST = BYTE_W'((1 << BIN_BYTE_W) - 1);
   localparam logic [BYTE_W-1:0] SEC_LAST = BYTE_W'(SEC_BYTES - 1);

   generate
      if (STD_PAGE_BYTES > (1 << BYTE_W) || STD_PAGE_BYTES <= (1 << (BYTE_W - 1))) begin : g_bad_std
         $error("STD_PAGE_BYTES must lie in (2**(BYTE_W-1), 2**BYTE_W]");
      end
      if (BIN_BYTE_W >= BYTE_W + 1 || (1 << BIN_BYTE_W) > STD_PAGE_BYTES) begin : g_bad_bin
         $error("binary page must not exceed the standard page");
      end
      if (SEC_BYTES < 1 || SEC_BYTES > (1 << BYTE_W)) begin : g_bad_sec
         $error("SEC_BYTES out of range");
      end
      if (NUM_PAGES < 1 || NUM_PAGES > (1 << PAGE_W)) begin : g_bad_pages
         $error("NUM_PAGES out of range");
      end
   endgenerate

   rd_kind_e          kind_q, kind_d;
   logic              bin_q, bin_d;
   logic              ok_q, ok_d;
   logic [PAGE_W-1:0] page_q, page_d, page_nxt, dec_page;
   logic [BYTE_W-1:0] byte_q, byte_d, byte_inc, dec_byte, byte_last;
   logic              at_end;
   rd_kind_e          kind_in;

   assign kind_in = rd_kind_e'(rd_type_i);

   prs_start_decode #(
      .PAGE_W        (PAGE_W),
      .BYTE_W        (BYTE_W),
      .BIN_BYTE_W    (BIN_BYTE_W),
      .STD_PAGE_BYTES(STD_PAGE_BYTES)
   ) u_dec (
      .addr_i(start_addr_i),
      .bin_i (bin_mode_i),
      .kind_i(kind_in),
      .page_o(dec_page),
      .byte_o(dec_byte)
   );

   always_comb begin
      if (kind_q == RK_SECR)  byte_last = SEC_LAST;
      else if (bin_q)         byte_last = BIN_LAST;
      else                    byte_last = STD_LAST;
   end

   prs_byte_step #(.BYTE_W(BYTE_W)) u_byte (
      .cur_i   (byte_q),
      .last_i  (byte_last),
      .at_end_o(at_end),
      .inc_o   (byte_inc)
   );

   prs_page_step #(.PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES)) u_page (
      .cur_i(page_q),
      .nxt_o(page_nxt)
   );

   always_comb begin
      page_d = page_q;
      byte_d = byte_q;
      ok_d   = ok_q;
      kind_d = kind_q;
      bin_d  = bin_q;
      if (load_i) begin
         page_d = dec_page;
         byte_d = dec_byte;
         ok_d   = 1'b1;
         kind_d = kind_in;
         bin_d  = bin_mode_i;
      end else if (next_i && ok_q) begin
         case (kind_q)
            RK_PAGE: byte_d = at_end ? '0 : byte_inc;
            RK_SECR: begin
               if (at_end) ok_d   = 1'b0;
               else        byte_d = byte_inc;
            end
            default: begin
               if (at_end) begin
                  byte_d = '0;
                  page_d = page_nxt;
               end else begin
                  byte_d = byte_inc;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         byte_q <= '0;
         ok_q   <= 1'b0;
         kind_q <= RK_CONT;
         bin_q  <= 1'b0;
      end else begin
         page_q <= page_d;
         byte_q <= byte_d;
         ok_q   <= ok_d;
         kind_q <= kind_d;
         bin_q  <= bin_d;
      end
   end

   assign page_o  = page_q;
   assign byte_o  = byte_q;
   assign valid_o = ok_q;

   // R10
   byte_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_q |-> (byte_q <= byte_last));

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ok_q && !load_i) |=> (!ok_q && $stable(page_q) && $stable(byte_q)));

   // R3
   cont_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_q && next_i && !load_i && (kind_q == RK_CONT || kind_q == RK_ALT) && at_end)
      |=> (byte_q == '0 && page_q != $past(page_q)));

   // R4
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_q && next_i && !load_i && kind_q == RK_PAGE) |=> $stable(page_q));

   // R7
   sec_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_q && next_i && !load_i && kind_q == RK_SECR && at_end)
      |=> (!ok_q && $stable(byte_q)));

   // R8
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> ok_q);

endmodule

// File: tb/paged_rd_seq_test.sv
`timescale 1ns/1ps
module paged_rd_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [19:0] start_addr_i = '0;
   logic [1:0]  rd_type_i = '0;
   logic        bin_mode_i = 1'b0;
   logic        next_i = 1'b0;
   logic [10:0] page_o;
   logic [8:0]  byte_o;
   logic        valid_o;

   int n_run = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   paged_rd_seq uut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
      .rd_type_i(rd_type_i), .bin_mode_i(bin_mode_i), .next_i(next_i),
      .page_o(page_o), .byte_o(byte_o), .valid_o(valid_o)
   );

   // op[1:0] (bit0 load, bit1 next), addr, type, bin, exp page, exp byte, exp valid, req
   localparam int NV = 21;
   localparam logic [49:0] VEC [NV] = '{
      {2'd1, 20'd2822,    2'd0, 1'b0, 11'd5,    9'd262, 1'b1, 4'd2},  // R2 standard load
      {2'd2, 20'd0,       2'd0, 1'b0, 11'd5,    9'd263, 1'b1, 4'd3},  // R3 step
      {2'd2, 20'd0,       2'd1, 1'b1, 11'd6,    9'd0,   1'b1, 4'd9},  // R9 inputs changed, still crosses
      {2'd2, 20'd0,       2'd0, 1'b0, 11'd6,    9'd1,   1'b1, 4'd3},  // R3
      {2'd1, 20'd3847,    2'd1, 1'b0, 11'd7,    9'd263, 1'b1, 4'd2},  // R2
      {2'd2, 20'd0,       2'd0, 1'b0, 11'd7,    9'd0,   1'b1, 4'd4},  // R4 wrap in page
      {2'd2, 20'd0,       2'd0, 1'b0, 11'd7,    9'd1,   1'b1, 4'd4},  // R4
      {2'd1, 20'd1048327, 2'd0, 1'b0, 11'd2047, 9'd263, 1'b1, 4'd2},  // R2
      {2'd2, 20'd0,       2'd0, 1'b0, 11'd0,    9'd0,   1'b1, 4'd5},  // R5 last page wrap
      {2'd1, 20'd1836,    2'd0, 1'b0, 11'd3,    9'd36,  1'b1, 4'd6},  // R6 clamp 300
      {2'd1, 20'd1023,    2'd1, 1'b0, 11'd1,    9'd247, 1'b1, 4'd6},  // R6 clamp 511
      {2'd1, 20'd4863,    2'd0, 1'b1, 11'd18,   9'd255, 1'b1, 4'd2},  // R2 binary load
      {2'd2, 20'd0,       2'd0, 1'b1, 11'd19,   9'd0,   1'b1, 4'd3},  // R3 binary cross
      {2'd1, 20'd16639,   2'd1, 1'b1, 11'd64,   9'd255, 1'b1, 4'd2},  // R2
      {2'd2, 20'd0,       2'd1, 1'b1, 11'd64,   9'd0,   1'b1, 4'd4},  // R4 binary wrap
      {2'd1, 20'd1048575, 2'd0, 1'b1, 11'd2047, 9'd255, 1'b1, 4'd2},  // R2 bit 19 ignored
      {2'd2, 20'd0,       2'd0, 1'b1, 11'd0,    9'd0,   1'b1, 4'd5},  // R5 binary wrap
      {2'd1, 20'd4871,    2'd3, 1'b0, 11'd9,    9'd263, 1'b1, 4'd2},  // R2 spare type
      {2'd2, 20'd0,       2'd3, 1'b0, 11'd10,   9'd0,   1'b1, 4'd3},  // R3 spare type continuous
      {2'd3, 20'd2148,    2'd1, 1'b0, 11'd4,    9'd100, 1'b1, 4'd8},  // R8 load beats next
      {2'd2, 20'd0,       2'd1, 1'b0, 11'd4,    9'd101, 1'b1, 4'd4}   // R4
   };

   task automatic check(input int req, input logic [10:0] ep, input logic [8:0] eb, input logic ev);
      n_run++;
      if (page_o !== ep || byte_o !== eb || valid_o !== ev) begin
         n_bad++;
         $display("FAIL R%0d: page=%0d byte=%0d valid=%0b expected page=%0d byte=%0d valid=%0b",
                  req, page_o, byte_o, valid_o, ep, eb, ev);
      end
   endtask

   task automatic apply(input logic [1:0] op, input logic [19:0] a, input logic [1:0] t, input logic b);
      @(negedge clk);
      load_i       = op[0];
      next_i       = op[1];
      start_addr_i = a;
      rd_type_i    = t;
      bin_mode_i   = b;
      @(posedge clk);
      #1;
      load_i = 1'b0;
      next_i = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_run++;
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, 11'd0, 9'd0, 1'b0);                 // R1 reset state
      apply(2'd2, 20'd0, 2'd0, 1'b0);
      check(1, 11'd0, 9'd0, 1'b0);                 // R1 next ignored before load

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][49:48], VEC[i][47:28], VEC[i][27:26], VEC[i][25]);
         check(int'(VEC[i][3:0]), VEC[i][24:14], VEC[i][13:5], VEC[i][4]);
      end

      // R7 security read walk
      apply(2'd1, 20'hFFFFF, 2'd2, 1'b1);
      check(7, 11'd0, 9'd0, 1'b1);
      for (int k = 1; k < 128; k++) begin
         apply(2'd2, 20'd0, 2'd2, 1'b0);
         check(7, 11'd0, 9'(k), 1'b1);
      end
      apply(2'd2, 20'd0, 2'd2, 1'b0);
      check(7, 11'd0, 9'd127, 1'b0);
      apply(2'd2, 20'd0, 2'd0, 1'b0);
      check(7, 11'd0, 9'd127, 1'b0);

      // R1 reset mid-stream
      apply(2'd1, 20'd2822, 2'd0, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, 11'd0, 9'd0, 1'b0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

endmodule